// File: doc/BRIEF.md
# Audio Channel FIFO with Sample Packing

This block is one transmit/receive channel pair that sits between a 32-bit bus-side data port and an audio sample stream. On the transmit side the bus writes whole 32-bit words into a FIFO. An unpacker then hands the words out on a valid/ready stream, either as one full word per beat or split into narrower samples. On the receive side a packer gathers stream samples into 32-bit words, and a FIFO holds them until the bus reads them. Each direction has its own enable, packing selection, level threshold and single-cycle soft reset. Status outputs give the free-entry count, a threshold trigger that a DMA engine can use as its request, and a sticky error flag.

The stream ports follow valid/ready rules. The transmit stream holds `txs_data` steady while `txs_valid` is high and `txs_ready` is low, and a beat is taken only in a cycle where both are high. The receive stream takes a sample only in a cycle where `rxs_valid` and `rxs_ready` are both high. `rxs_ready` is high only while the receive FIFO has room, so a stalled bus read pushes back on the sender. The bus side has no handshake. A write strobe against a full FIFO is lost, and a read strobe against an empty FIFO returns zero. A loopback control feeds the unpacked transmit samples straight into the receive packer. Pack selections should change only in the same cycle as that direction's soft reset.

Packing is chosen per direction by a pack-enable bit and a 2-bit mode. With pack-enable set, mode 3 gives 16-bit samples and mode 2 gives 8-bit samples. Any other setting gives unpacked 32-bit samples. `DEPTH` (default 64) must not exceed 255 so that the 8-bit status counts can hold it.

Top module: `audio_chan_fifo`

## Requirements
- R1: After reset both FIFOs are empty, `tx_free` and `rx_free` equal DEPTH, `txs_valid`, `tx_ovf`, `rx_udf` and `bus_rd_data` are zero.
- R2: With 32-bit samples (pack-enable clear, or mode 0/1), each word written by the bus leaves on the transmit stream as one beat, in write order.
- R3: A bus write while the transmit FIFO holds DEPTH words is dropped and sets `tx_ovf`, which stays set until the transmit soft reset.
- R4: With transmit mode 3 and pack-enable set, each word gives two beats: bits 15:0 first, then bits 31:16, both zero-extended to 32 bits.
- R5: With transmit mode 2 and pack-enable set, each word gives four beats: bits 7:0, 15:8, 23:16, then 31:24, each zero-extended.
- R6: The receive packer takes samples into words lowest slice first. In 16-bit mode the first sample fills bits 15:0 and the second fills bits 31:16. In 8-bit mode four samples fill the word from bits 7:0 upward. Only the low bits of each sample are kept, and a word enters the FIFO once it is complete.
- R7: `bus_rd_data` is updated on the clock edge where `bus_rd_en` is sampled. It then holds the oldest received word, or zero if the receive FIFO was empty. An empty read also sets the sticky `rx_udf`.
- R8: `tx_free` and `rx_free` equal DEPTH minus the number of words held in each FIFO.
- R9: `tx_trig` is high when `tx_en` is set and `tx_free` is at least `tx_thresh`. `rx_trig` is high when `rx_en` is set and the number of filled receive words is at least `rx_thresh`.
- R10: With `tx_en` low, `txs_valid` is low. With `rx_en` low, `rxs_ready` is low. While `txs_valid` is high and `txs_ready` is low, `txs_data` does not change.
- R11: With `loopback` set, `txs_valid` and `rxs_ready` are held low, and transmit samples pass directly into the receive packer under the same handshake.
- R12: A soft reset on one direction takes effect at the next edge. It empties that FIFO, drops any partly packed or unpacked word and clears that direction's sticky flag. During the reset cycle that direction's stream handshake and bus access are blocked, and the other direction is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit stream enable |
| rx_en | input | 1 | Receive stream enable |
| loopback | input | 1 | Route transmit samples into the receive packer |
| tx_pack_en | input | 1 | Transmit packing enable |
| tx_pack_mode | input | 2 | Transmit pack mode (3: 16-bit, 2: 8-bit) |
| rx_pack_en | input | 1 | Receive packing enable |
| rx_pack_mode | input | 2 | Receive pack mode (3: 16-bit, 2: 8-bit) |
| tx_thresh | input | 8 | Transmit free-entry threshold |
| rx_thresh | input | 8 | Receive filled-entry threshold |
| tx_srst | input | 1 | Transmit soft reset |
| rx_srst | input | 1 | Receive soft reset |
| bus_wr_en | input | 1 | Bus write strobe into the transmit FIFO |
| bus_wr_data | input | 32 | Bus write word |
| bus_rd_en | input | 1 | Bus read strobe from the receive FIFO |
| bus_rd_data | output | 32 | Registered bus read word |
| txs_valid | output | 1 | Transmit stream valid |
| txs_ready | input | 1 | Transmit stream ready |
| txs_data | output | 32 | Transmit stream sample |
| rxs_valid | input | 1 | Receive stream valid |
| rxs_ready | output | 1 | Receive stream ready |
| rxs_data | input | 32 | Receive stream sample |
| tx_free | output | 8 | Free transmit FIFO entries |
| rx_free | output | 8 | Free receive FIFO entries |
| tx_trig | output | 1 | Transmit threshold trigger |
| rx_trig | output | 1 | Receive threshold trigger |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The bound checker watches several rules on every clock: stream data stability under back-pressure, the gating by enable and loopback, the bounds on free counts, the stickiness of both error flags, the state right after a soft reset, and the zero result and flag of an empty read. Its view is local in time. Sample order within a packed word and word order through each FIFO can only be shown by the bench's reference model over whole scenarios. The same holds for exact free counts and triggers against programmed thresholds, and for the loopback path across mismatched pack widths.

// File: rtl/acf_pkg.sv
package acf_pkg;
  typedef enum logic [1:0] {SW32 = 2'd0, SW16 = 2'd1, SW8 = 2'd2} samp_w_e;

  function automatic samp_w_e pick_width(input logic pe, input logic [1:0] m);
    if (pe && m == 2'd3) return SW16;
    if (pe && m == 2'd2) return SW8;
    return SW32;
  endfunction

  function automatic logic is_last(input samp_w_e w, input logic [1:0] idx);
    case (w)
      SW16:    return idx[0];
      SW8:     return idx == 2'd3;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/acf_fifo.sv
module acf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (count == FULLC);
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/acf_tx_unpack.sv
module acf_tx_unpack
  import acf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  samp_w_e     mode,
  input  logic [31:0] head,
  input  logic        empty,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        pop
);
  logic [1:0] idx;
  logic fire;

  assign out_valid = en && !empty && !clr;
  assign fire      = out_valid && out_ready;
  assign pop       = fire && is_last(mode, idx);

  always_comb begin
    case (mode)
      SW16:    out_data = {16'b0, idx[0] ? head[31:16] : head[15:0]};
      SW8:     out_data = {24'b0, head[8*idx +: 8]};
      default: out_data = head;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (fire) idx <= is_last(mode, idx) ? 2'd0 : idx + 2'd1;
  end
endmodule

// File: rtl/acf_rx_pack.sv
module acf_rx_pack
  import acf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  samp_w_e     mode,
  input  logic        full,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        push,
  output logic [31:0] push_data
);
  logic [1:0]  idx;
  logic [31:0] acc, ins;
  logic fire;

  assign in_ready  = en && !full && !clr;
  assign fire      = in_valid && in_ready;
  assign push      = fire && is_last(mode, idx);
  assign push_data = acc | ins;

  always_comb begin
    case (mode)
      SW16:    ins = idx[0] ? {in_data[15:0], 16'b0} : {16'b0, in_data[15:0]};
      SW8:     ins = 32'(in_data[7:0]) << (8 * idx);
      default: ins = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; acc <= '0;
    end else if (clr) begin
      idx <= '0; acc <= '0;
    end else if (fire) begin
      if (is_last(mode, idx)) begin
        idx <= '0; acc <= '0;
      end else begin
        idx <= idx + 2'd1; acc <= acc | ins;
      end
    end
  end
endmodule

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo
  import acf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        rx_en,
  input  logic        loopback,
  input  logic        tx_pack_en,
  input  logic [1:0]  tx_pack_mode,
  input  logic        rx_pack_en,
  input  logic [1:0]  rx_pack_mode,
  input  logic [7:0]  tx_thresh,
  input  logic [7:0]  rx_thresh,
  input  logic        tx_srst,
  input  logic        rx_srst,
  input  logic        bus_wr_en,
  input  logic [31:0] bus_wr_data,
  input  logic        bus_rd_en,
  output logic [31:0] bus_rd_data,
  output logic        txs_valid,
  input  logic        txs_ready,
  output logic [31:0] txs_data,
  input  logic        rxs_valid,
  output logic        rxs_ready,
  input  logic [31:0] rxs_data,
  output logic [7:0]  tx_free,
  output logic [7:0]  rx_free,
  output logic        tx_trig,
  output logic        rx_trig,
  output logic        tx_ovf,
  output logic        rx_udf
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [31:0]   tx_head, rx_head, unp_data, pk_data, pk_in;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_pop, unp_valid, unp_ready;
  logic pk_push, pk_ready, pk_valid;
  samp_w_e tx_w, rx_w;

  assign tx_w = pick_width(tx_pack_en, tx_pack_mode);
  assign rx_w = pick_width(rx_pack_en, rx_pack_mode);

  acf_fifo #(.DW(32), .DEPTH(DEPTH)) u_tx_fifo (
    .clk, .rst_n, .clr(tx_srst), .push(bus_wr_en), .wdata(bus_wr_data),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  acf_tx_unpack u_unpack (
    .clk, .rst_n, .clr(tx_srst), .en(tx_en), .mode(tx_w), .head(tx_head),
    .empty(tx_empty), .out_ready(unp_ready), .out_valid(unp_valid),
    .out_data(unp_data), .pop(tx_pop));

  // Loopback steers the unpacker into the packer and closes the external ports
  assign unp_ready = loopback ? pk_ready : txs_ready;
  assign txs_valid = unp_valid && !loopback;
  assign txs_data  = unp_data;
  assign pk_valid  = loopback ? unp_valid : rxs_valid;
  assign pk_in     = loopback ? unp_data : rxs_data;
  assign rxs_ready = pk_ready && !loopback;

  acf_rx_pack u_pack (
    .clk, .rst_n, .clr(rx_srst), .en(rx_en), .mode(rx_w), .full(rx_full),
    .in_valid(pk_valid), .in_data(pk_in), .in_ready(pk_ready),
    .push(pk_push), .push_data(pk_data));

  acf_fifo #(.DW(32), .DEPTH(DEPTH)) u_rx_fifo (
    .clk, .rst_n, .clr(rx_srst), .push(pk_push), .wdata(pk_data),
    .pop(bus_rd_en && !rx_srst), .rdata(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  assign tx_free = 8'(DEPTH_C - tx_cnt);
  assign rx_free = 8'(DEPTH_C - rx_cnt);
  assign tx_trig = tx_en && (tx_free >= tx_thresh);
  assign rx_trig = rx_en && (8'(rx_cnt) >= rx_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                tx_ovf <= 1'b0;
    else if (tx_srst)                          tx_ovf <= 1'b0;
    else if (bus_wr_en && tx_full)             tx_ovf <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_udf <= 1'b0; bus_rd_data <= '0;
    end else if (rx_srst) begin
      rx_udf <= 1'b0;
    end else if (bus_rd_en) begin
      bus_rd_data <= rx_empty ? 32'd0 : rx_head;
      if (rx_empty) rx_udf <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_chan_fifo_chk.sv
module audio_chan_fifo_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_en,
  input logic        rx_en,
  input logic        loopback,
  input logic        tx_srst,
  input logic        rx_srst,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [31:0] bus_rd_data,
  input logic        txs_valid,
  input logic        txs_ready,
  input logic [31:0] txs_data,
  input logic        rxs_ready,
  input logic [7:0]  tx_free,
  input logic [7:0]  rx_free,
  input logic        tx_trig,
  input logic        rx_trig,
  input logic        tx_ovf,
  input logic        rx_udf
);
  localparam logic [7:0] DEP8 = 8'(DEPTH);

  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txs_valid && !txs_ready && !tx_srst |=> tx_srst || !tx_en || loopback || (txs_valid && $stable(txs_data)));
  p_tx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !txs_valid);
  p_rx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rxs_ready);
  p_loop_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> !txs_valid && !rxs_ready);
  p_free_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_free <= DEP8 && rx_free <= DEP8);
  p_trig_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_trig |-> tx_en) and (rx_trig |-> rx_en));
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf && !tx_srst |=> tx_ovf);
  p_full_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && tx_free == 8'd0 && !tx_srst |=> tx_ovf);
  p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_udf && !rx_srst |=> rx_udf);
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en && rx_free == DEP8 && !rx_srst |=> bus_rd_data == 32'd0 && rx_udf);
  p_tx_srst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_srst |=> tx_free == DEP8 && !tx_ovf);
  p_rx_srst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_srst |=> rx_free == DEP8 && !rx_udf);
endmodule

bind audio_chan_fifo audio_chan_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .loopback(loopback),
  .tx_srst(tx_srst), .rx_srst(rx_srst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_rd_data(bus_rd_data), .txs_valid(txs_valid), .txs_ready(txs_ready),
  .txs_data(txs_data), .rxs_ready(rxs_ready), .tx_free(tx_free), .rx_free(rx_free),
  .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_ovf(tx_ovf), .rx_udf(rx_udf));

// File: tb/audio_chan_fifo_tb.sv
module audio_chan_fifo_tb;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, loopback = 0, tx_pack_en = 0, rx_pack_en = 0;
  logic [1:0] tx_pack_mode = 0, rx_pack_mode = 0;
  logic [7:0] tx_thresh = 0, rx_thresh = 0;
  logic tx_srst = 0, rx_srst = 0, bus_wr_en = 0, bus_rd_en = 0;
  logic [31:0] bus_wr_data = 0, rxs_data = 0;
  logic txs_ready = 0, rxs_valid = 0;
  logic [31:0] bus_rd_data, txs_data;
  logic txs_valid, rxs_ready, tx_trig, rx_trig, tx_ovf, rx_udf;
  logic [7:0] tx_free, rx_free;

  always #4 clk = ~clk;

  audio_chan_fifo #(.DEPTH(DEPTH)) u_dut (.*);

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  string cur = "R1";

  // Behavioural reference state
  logic [31:0] txq[$], rxq[$];
  int tidx = 0, ridx = 0;
  logic [31:0] racc = 0, m_rd = 0;
  bit m_ovf = 0, m_udf = 0;

  function automatic int wd(logic pe, logic [1:0] m);
    if (pe && m == 2'd3) return 16;
    if (pe && m == 2'd2) return 8;
    return 32;
  endfunction

  function automatic logic [31:0] slc(logic [31:0] w, int i, int b);
    if (b == 32) return w;
    if (b == 16) return (w >> (16 * i)) & 32'hFFFF;
    return (w >> (8 * i)) & 32'hFF;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur, what, cycles, act, exp);
    end
  endtask

  task automatic tick();
    int tw, rw;
    bit tv, rr, tfire, rfire;
    logic [31:0] td, rs;
    #1;
    tw = wd(tx_pack_en, tx_pack_mode);
    rw = wd(rx_pack_en, rx_pack_mode);
    tv = rst_n && tx_en && txq.size() > 0 && !tx_srst;
    td = (txq.size() > 0) ? slc(txq[0], tidx, tw) : 32'd0;
    rr = rst_n && rx_en && rxq.size() < DEPTH && !rx_srst;
    if (loopback) begin
      tfire = tv && rr; rfire = tfire; rs = td;
    end else begin
      tfire = tv && txs_ready; rfire = rxs_valid && rr; rs = rxs_data;
    end
    chk("txs_valid", 32'(txs_valid), 32'(tv && !loopback));
    if (tv && !loopback) chk("txs_data", txs_data, td);
    chk("rxs_ready", 32'(rxs_ready), 32'(rr && !loopback));
    chk("tx_free(R8)", 32'(tx_free), 32'(DEPTH - txq.size()));
    chk("rx_free(R8)", 32'(rx_free), 32'(DEPTH - rxq.size()));
    chk("tx_trig(R9)", 32'(tx_trig), 32'(tx_en && (DEPTH - txq.size()) >= int'(tx_thresh)));
    chk("rx_trig(R9)", 32'(rx_trig), 32'(rx_en && rxq.size() >= int'(rx_thresh)));
    chk("tx_ovf", 32'(tx_ovf), 32'(m_ovf));
    chk("rx_udf", 32'(rx_udf), 32'(m_udf));
    chk("bus_rd_data", bus_rd_data, m_rd);
    @(posedge clk);
    cycles++;
    if (!rst_n) begin
      txq.delete(); rxq.delete(); tidx = 0; ridx = 0; racc = 0; m_rd = 0; m_ovf = 0; m_udf = 0;
    end else begin
      if (tx_srst) begin
        txq.delete(); tidx = 0; m_ovf = 0;
      end else begin
        bit was_full = (txq.size() == DEPTH);
        if (tfire) begin
          if (tidx == 32 / tw - 1) begin void'(txq.pop_front()); tidx = 0; end
          else tidx++;
        end
        if (bus_wr_en) begin
          if (was_full) m_ovf = 1; else txq.push_back(bus_wr_data);
        end
      end
      if (rx_srst) begin
        rxq.delete(); ridx = 0; racc = 0; m_udf = 0;
      end else begin
        if (bus_rd_en) begin
          if (rxq.size() == 0) begin m_rd = 0; m_udf = 1; end
          else m_rd = rxq.pop_front();
        end
        if (rfire) begin
          logic [31:0] ins = (rw == 32) ? rs : (slc(rs, 0, rw) << (rw * ridx));
          if (ridx == 32 / rw - 1) begin rxq.push_back(racc | ins); racc = 0; ridx = 0; end
          else begin racc = racc | ins; ridx++; end
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic run(int n, int pw, int pr, int prdy, int pval);
    for (int i = 0; i < n; i++) begin
      bus_wr_en   = ($urandom % 100) < pw;
      bus_wr_data = $urandom;
      bus_rd_en   = ($urandom % 100) < pr;
      txs_ready   = ($urandom % 100) < prdy;
      rxs_valid   = ($urandom % 100) < pval;
      rxs_data    = $urandom;
      tick();
    end
    bus_wr_en = 0; bus_rd_en = 0;
  endtask

  task automatic set_tx(logic pe, logic [1:0] m);
    tx_srst = 1; tx_pack_en = pe; tx_pack_mode = m;
    tick();
    tx_srst = 0;
  endtask

  task automatic set_rx(logic pe, logic [1:0] m);
    rx_srst = 1; rx_pack_en = pe; rx_pack_mode = m;
    tick();
    rx_srst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1): run hung, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur = "R1";  repeat (3) tick();
    rst_n = 1;   repeat (2) tick();
    cur = "R2";  tx_en = 1; tx_pack_en = 1; tx_pack_mode = 2'd1; run(60, 40, 0, 50, 0);
    tx_pack_en = 0; run(40, 30, 0, 70, 0);
    cur = "R10"; tx_en = 0; tx_thresh = 8'd50; run(30, 60, 0, 100, 0);
    cur = "R9";  tx_en = 1; run(20, 0, 0, 0, 0);
    cur = "R3";  run(80, 100, 0, 0, 0); run(20, 50, 0, 100, 0);
    cur = "R12"; set_tx(1'b1, 2'd3); run(5, 0, 0, 0, 0);
    cur = "R4";  tx_thresh = 8'd60; run(120, 30, 0, 60, 0);
    cur = "R5";  set_tx(1'b1, 2'd2); run(160, 20, 0, 70, 0);
    cur = "R6";  rx_en = 1; rx_thresh = 8'd3; set_rx(1'b1, 2'd3); run(120, 0, 20, 0, 60);
    set_rx(1'b1, 2'd2); run(160, 0, 10, 0, 70);
    set_rx(1'b0, 2'd3); run(60, 0, 30, 0, 60);
    cur = "R7";  run(40, 0, 100, 0, 0); run(10, 0, 0, 0, 0);
    cur = "R8";  run(120, 0, 0, 0, 90); run(40, 0, 60, 0, 0);
    cur = "R10"; rx_en = 0; run(30, 0, 20, 0, 100); rx_en = 1;
    cur = "R11"; loopback = 1; set_tx(1'b1, 2'd2); set_rx(1'b1, 2'd3);
    run(200, 30, 30, 50, 50);
    set_tx(1'b1, 2'd3); set_rx(1'b0, 2'd0); run(150, 30, 40, 50, 50);
    loopback = 0;
    cur = "R12"; set_rx(1'b1, 2'd2); set_tx(1'b1, 2'd2);
    for (int k = 0; k < 300; k++) begin
      tx_srst = ($urandom % 40) == 0;
      rx_srst = ($urandom % 40) == 0;
      rx_thresh = 8'($urandom % 6);
      tx_thresh = 8'($urandom % 66);
      run(1, 40, 30, 60, 60);
    end
    tx_srst = 0; rx_srst = 0;
    cur = "R9";  run(40, 50, 10, 10, 80);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule